// File: doc/BRIEF.md
# Programmable Divider Chain with Test Output Selector

This block is a cycle-level digital model of a frequency synthesizer's divider datapath. It runs on one system clock; the fast oscillator, the crystal and the serial programming clock are each represented by an enable strobe. Each strobe marks one half-period of the clock it stands for, so a strobe on every system cycle models a clock running at half the system clock rate. The crystal strobe drives a fixed reference divider that divides by sixteen. The oscillator strobe drives two dividers. The first is a programmable feedback divider by M; its output is a narrow pulse rather than a square wave. The second is an output divider by N; its output is a clean 50% square wave that forms the main output. A further stage divides the main output by four.

A 3-bit test code selects which internal signal appears on a test output. Two codes force constant levels, and one code passes an external shift-register bit straight through. One code also swaps the divider source: the serial clock strobe replaces the oscillator strobe for both the M and the N divider. A newly programmed M or N is adopted only when its divider reaches terminal count, so the period in progress always completes at its old length and no runt pulse appears.

Top module: `synth_div_chain`

## Requirements
- R1: With test code 010 the test output shows the reference divider output. This output is low for 8 crystal strobes and then high for 8, with a period of 16 strobes. Its first rising edge follows the 8th crystal strobe after reset.
- R2: The feedback divider output has a period of 2*M source strobes and is high for exactly one strobe interval. Its first rise follows the 2*M-th source strobe after reset. This holds for any M from 250 to 511 on the 9-bit `mValue`.
- R3: The main output `fOut` is a 50% square wave with a half-period of N source strobes. The N code maps 00, 01, 10 and 11 to N = 1, 2, 4 and 8. The first rise after reset follows the N-th source strobe.
- R4: With test code 111 the test output is `fOut` divided by four. It is a 50% wave with a half-period of 4*N source strobes.
- R5: Test code 000 passes `shiftIn` to the test output, code 001 drives it high and code 101 drives it low, whatever the dividers are doing.
- R6: Test code 011 shows the feedback divider output on the test output, and test code 100 shows `fOut`.
- R7: With test code 110, both the M and the N divider count `sclkEn` strobes instead of `vcoEn` strobes, and `vcoEn` has no effect on them. The test output then shows the feedback divider output.
- R8: A change of `mValue` or `nCode` takes effect only at the divider's next terminal count. The period or half-period in progress completes at its old length.
- R9: A synchronous `rst` clears every divider counter and forces the reference, feedback, main and divide-by-four outputs low. It loads the current M and N settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vcoEn | input | 1 | Oscillator half-period strobe |
| xtalEn | input | 1 | Crystal half-period strobe |
| sclkEn | input | 1 | Serial clock half-period strobe |
| shiftIn | input | 1 | Shift register serial output bit |
| mValue | input | 9 | Feedback divide ratio M |
| nCode | input | 2 | Output divider code (00/01/10/11 = 1/2/4/8) |
| testCode | input | 3 | Test output selection code |
| fOut | output | 1 | Main divided output |
| testOut | output | 1 | Selected test signal |

## Verification
The hardest situation to reach from the ports is a ratio change that lands in the middle of a count. The bench waits for a measured rising edge, lets a known number of cycles pass, and then changes `nCode` or `mValue`. It then times the remainder of that interval and the one after, which shows whether the old ratio was kept to terminal count. The serial-clock source swap is made visible by toggling `sclkEn` at half the rate of a continuously asserted `vcoEn`. The measured periods then double only if the right source was picked.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int TEST_W = 3;
  localparam int SEL_N  = 1 << TEST_W;

  localparam logic [TEST_W-1:0] CODE_SHIFT  = 3'b000;
  localparam logic [TEST_W-1:0] CODE_HIGH   = 3'b001;
  localparam logic [TEST_W-1:0] CODE_REF    = 3'b010;
  localparam logic [TEST_W-1:0] CODE_FBK    = 3'b011;
  localparam logic [TEST_W-1:0] CODE_OUT    = 3'b100;
  localparam logic [TEST_W-1:0] CODE_LOW    = 3'b101;
  localparam logic [TEST_W-1:0] CODE_SERIAL = 3'b110;
  localparam logic [TEST_W-1:0] CODE_QUART  = 3'b111;

  typedef struct packed {
    logic refTick;
    logic divTick;
  } divStrobe_t;
endpackage

// File: rtl/synth_div_ctrl.sv
module synth_div_ctrl
  import synth_div_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  vcoEn,
  input  logic                  xtalEn,
  input  logic                  sclkEn,
  input  logic [TEST_W-1:0]     testCode,
  output divStrobe_t            strb,
  output logic [SEL_N-1:0]      selHot
);

  logic serialSrc;

  assign serialSrc    = (testCode == CODE_SERIAL);
  assign strb.refTick = xtalEn;
  assign strb.divTick = serialSrc ? sclkEn : vcoEn;

  for (genvar i = 0; i < SEL_N; i++) begin : g_dec
    assign selHot[i] = (testCode == TEST_W'(i));
  end

  // R6: exactly one test source is selected at any time
  assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(selHot) == 1);

endmodule

// File: rtl/synth_div_datapath.sv
module synth_div_datapath
  import synth_div_pkg::*;
#(
  parameter int M_W     = 9,
  parameter int N_W     = 2,
  parameter int REF_DIV = 16,
  parameter int OUT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  divStrobe_t        strb,
  input  logic [SEL_N-1:0]  selHot,
  input  logic [M_W-1:0]    mValue,
  input  logic [N_W-1:0]    nCode,
  input  logic              shiftIn,
  output logic              fOut,
  output logic              testOut
);

  localparam int REF_W = $clog2(REF_DIV);
  localparam int MC_W  = M_W + 1;
  localparam int NC_W  = (1 << N_W) - 1;
  localparam int D4_W  = $clog2(2 * OUT_DIV);

  // reference divider: REF_DIV crystal half-periods per output period
  logic [REF_W-1:0] refCnt;
  logic             refOut;

  always_ff @(posedge clk) begin
    if (rst)               refCnt <= '0;
    else if (strb.refTick) refCnt <= refCnt + 1'b1;
  end
  assign refOut = refCnt[REF_W-1];

  // feedback divider: one-strobe pulse every 2*M strobes
  logic [M_W-1:0]  mActive;
  logic [MC_W-1:0] mCnt;
  logic [MC_W-1:0] mTerm;
  logic            mOut;

  assign mTerm = {mActive, 1'b0} - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      mCnt    <= '0;
      mOut    <= 1'b0;
      mActive <= mValue;
    end else if (strb.divTick) begin
      if (mCnt == mTerm) begin
        mCnt    <= '0;
        mOut    <= 1'b1;
        mActive <= mValue;
      end else begin
        mCnt <= mCnt + 1'b1;
        mOut <= 1'b0;
      end
    end
  end

  // output divider: toggles every 2^nActive strobes
  logic [N_W-1:0]  nActive;
  logic [NC_W-1:0] nCnt;
  logic [NC_W-1:0] nLimit;
  logic            nTerm;

  always_comb begin
    nLimit = '0;
    for (int b = 0; b < NC_W; b++) begin
      if (b < int'(nActive)) nLimit[b] = 1'b1;
    end
  end
  assign nTerm = (nCnt == nLimit);

  always_ff @(posedge clk) begin
    if (rst) begin
      nCnt    <= '0;
      fOut    <= 1'b0;
      nActive <= nCode;
    end else if (strb.divTick) begin
      if (nTerm) begin
        nCnt    <= '0;
        fOut    <= ~fOut;
        nActive <= nCode;
      end else begin
        nCnt <= nCnt + 1'b1;
      end
    end
  end

  // divide main output by OUT_DIV: count its half-period events
  logic [D4_W-1:0] d4Cnt;
  logic            div4Out;

  always_ff @(posedge clk) begin
    if (rst)                         d4Cnt <= '0;
    else if (strb.divTick && nTerm)  d4Cnt <= d4Cnt + 1'b1;
  end
  assign div4Out = d4Cnt[D4_W-1];

  // test output selector
  logic [SEL_N-1:0] srcVec;

  always_comb begin
    srcVec              = '0;
    srcVec[CODE_SHIFT]  = shiftIn;
    srcVec[CODE_HIGH]   = 1'b1;
    srcVec[CODE_REF]    = refOut;
    srcVec[CODE_FBK]    = mOut;
    srcVec[CODE_OUT]    = fOut;
    srcVec[CODE_LOW]    = 1'b0;
    srcVec[CODE_SERIAL] = mOut;
    srcVec[CODE_QUART]  = div4Out;
  end
  assign testOut = |(selHot & srcVec);

  // R1: reference output moves only on a crystal strobe
  assert_ref_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strb.refTick |=> $stable(refOut));

  // R2: feedback pulse lasts a single strobe interval
  assert_m_width_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.divTick && mOut) |=> !mOut);

  // R2: feedback counter never passes its terminal value
  assert_m_bound_R2: assert property (@(posedge clk) disable iff (rst)
    (mActive != '0) |-> (mCnt <= mTerm));

  // R3: main output moves only on a divider strobe
  assert_fout_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !strb.divTick |=> $stable(fOut));

  // R4: quarter-rate output moves only on a divider strobe
  assert_quart_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !strb.divTick |=> $stable(div4Out));

  // R8: output counter stays within the adopted ratio
  assert_n_bound_R8: assert property (@(posedge clk) disable iff (rst)
    nCnt <= nLimit);

  // R9: reset leaves every divider cleared with outputs low
  assert_reset_R9: assert property (@(posedge clk)
    rst |=> (refCnt == '0 && mCnt == '0 && nCnt == '0 && d4Cnt == '0
             && !fOut && !mOut));

endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
#(
  parameter int M_W     = 9,
  parameter int N_W     = 2,
  parameter int REF_DIV = 16,
  parameter int OUT_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vcoEn,
  input  logic              xtalEn,
  input  logic              sclkEn,
  input  logic              shiftIn,
  input  logic [M_W-1:0]    mValue,
  input  logic [N_W-1:0]    nCode,
  input  logic [TEST_W-1:0] testCode,
  output logic              fOut,
  output logic              testOut
);

  divStrobe_t       strb;
  logic [SEL_N-1:0] selHot;

  synth_div_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .vcoEn    (vcoEn),
    .xtalEn   (xtalEn),
    .sclkEn   (sclkEn),
    .testCode (testCode),
    .strb     (strb),
    .selHot   (selHot)
  );

  synth_div_datapath #(
    .M_W     (M_W),
    .N_W     (N_W),
    .REF_DIV (REF_DIV),
    .OUT_DIV (OUT_DIV)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .selHot  (selHot),
    .mValue  (mValue),
    .nCode   (nCode),
    .shiftIn (shiftIn),
    .fOut    (fOut),
    .testOut (testOut)
  );

endmodule

// File: tb/synth_div_chain_bench.sv
`timescale 1ns/1ps
module synth_div_chain_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vcoEn = 1'b0;
  logic       xtalEn = 1'b0;
  logic       sclkEn = 1'b0;
  logic       sclkRun = 1'b0;
  logic       shiftIn = 1'b0;
  logic [8:0] mValue = 9'd250;
  logic [1:0] nCode = 2'b00;
  logic [2:0] testCode = 3'b010;
  logic       fOut;
  logic       testOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  synth_div_chain u_synth_div_chain (
    .clk(clk), .rst(rst), .vcoEn(vcoEn), .xtalEn(xtalEn), .sclkEn(sclkEn),
    .shiftIn(shiftIn), .mValue(mValue), .nCode(nCode), .testCode(testCode),
    .fOut(fOut), .testOut(testOut)
  );

  always @(negedge clk) begin
    if (sclkRun) sclkEn <= ~sclkEn;
    else         sclkEn <= 1'b0;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input bit useF);
    return useF ? fOut : testOut;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // cycles from reset release until the signal is first seen high
  task automatic firstRise(input bit useF, output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      if (pick(useF)) return;
    end
    n = -1;
  endtask

  task automatic waitRise(input bit useF);
    logic prev;
    prev = pick(useF);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (pick(useF) && !prev) return;
      prev = pick(useF);
    end
  endtask

  // called at a rising sample; measures period and high cycles
  task automatic fromRise(input bit useF, output int per, output int hi);
    logic prev;
    prev = 1'b1;
    hi = 1;
    per = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      per++;
      if (pick(useF) && !prev) return;
      if (pick(useF)) hi++;
      prev = pick(useF);
    end
    per = -1;
  endtask

  task automatic measure(input bit useF, output int per, output int hi);
    waitRise(useF);
    fromRise(useF, per, hi);
  endtask

  task automatic testReset();
    vcoEn = 1'b1; xtalEn = 1'b1; testCode = 3'b010;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 fOut low in reset", fOut, 0);
    check("R9 ref low in reset", testOut, 0);
    testCode = 3'b011; #0;
    check("R9 feedback low in reset", testOut, 0);
    testCode = 3'b111; #0;
    check("R9 quarter low in reset", testOut, 0);
    testCode = 3'b010;
  endtask

  task automatic testRef();
    int n, per, hi;
    testCode = 3'b010; xtalEn = 1'b1;
    doReset();
    firstRise(1'b0, n);
    check("R1 ref first rise", n, 8);
    measure(1'b0, per, hi);
    check("R1 ref period", per, 16);
    check("R1 ref high", hi, 8);
  endtask

  task automatic testFeedback();
    int n, per, hi;
    testCode = 3'b011; vcoEn = 1'b1; mValue = 9'd250;
    doReset();
    firstRise(1'b0, n);
    check("R2 feedback first rise M=250", n, 500);
    mValue = 9'd511;
    fromRise(1'b0, per, hi);
    check("R8 feedback period kept at old M", per, 500);
    fromRise(1'b0, per, hi);
    check("R2 feedback period M=511", per, 1022);
    check("R2 feedback pulse width", hi, 1);
  endtask

  task automatic testOutDiv();
    int n, per, hi;
    vcoEn = 1'b1;
    for (int c = 0; c < 4; c++) begin
      nCode = 2'(c);
      testCode = 3'b100;
      doReset();
      firstRise(1'b1, n);
      check("R3 fOut first rise", n, 1 << c);
      measure(1'b1, per, hi);
      check("R3 fOut period", per, 2 << c);
      check("R3 fOut high", hi, 1 << c);
      measure(1'b0, per, hi);
      check("R6 test code 100 period", per, 2 << c);
    end
  endtask

  task automatic testNChange();
    int n, per, hi;
    nCode = 2'b11; testCode = 3'b100; vcoEn = 1'b1;
    doReset();
    waitRise(1'b1);
    repeat (3) @(negedge clk);
    nCode = 2'b00;
    n = 0;
    for (int i = 0; i < 100 && fOut; i++) begin
      @(negedge clk);
      n++;
    end
    check("R8 half-period completes at old N", n, 5);
    measure(1'b1, per, hi);
    check("R8 new N adopted period", per, 2);
    check("R8 new N adopted high", hi, 1);
  endtask

  task automatic testQuarter();
    int per, hi;
    nCode = 2'b01; testCode = 3'b111; vcoEn = 1'b1;
    doReset();
    measure(1'b0, per, hi);
    check("R4 quarter period", per, 16);
    check("R4 quarter high", hi, 8);
  endtask

  task automatic testFixed();
    testCode = 3'b001; vcoEn = 1'b1;
    repeat (3) @(negedge clk);
    check("R5 code 001 high", testOut, 1);
    testCode = 3'b101;
    repeat (3) @(negedge clk);
    check("R5 code 101 low", testOut, 0);
    testCode = 3'b000; shiftIn = 1'b1;
    @(negedge clk);
    check("R5 code 000 shift bit 1", testOut, 1);
    shiftIn = 1'b0;
    @(negedge clk);
    check("R5 code 000 shift bit 0", testOut, 0);
  endtask

  task automatic testSerial();
    int per, hi;
    testCode = 3'b110; nCode = 2'b10; mValue = 9'd260;
    vcoEn = 1'b1; sclkRun = 1'b1;
    doReset();
    measure(1'b0, per, hi);
    check("R7 serial feedback period", per, 1040);
    check("R7 serial feedback high", hi, 2);
    measure(1'b1, per, hi);
    check("R7 serial fOut period", per, 16);
    check("R7 serial fOut high", hi, 8);
    vcoEn = 1'b0;
    measure(1'b1, per, hi);
    check("R7 vcoEn ignored period", per, 16);
    sclkRun = 1'b0; vcoEn = 1'b1;
  endtask

  task automatic testMidReset();
    int n;
    testCode = 3'b011; mValue = 9'd250; nCode = 2'b10;
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 fOut low after mid-run reset", fOut, 0);
    check("R9 feedback low after mid-run reset", testOut, 0);
    @(negedge clk);
    rst = 1'b0;
    firstRise(1'b0, n);
    check("R9 counter restarts from zero", n, 500);
  endtask

  initial begin
    testReset();
    testRef();
    testFeedback();
    testOutDiv();
    testNChange();
    testQuarter();
    testFixed();
    testSerial();
    testMidReset();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule